// File: doc/BRIEF.md
# 32-Request Cascaded Priority Encoder

This block takes 32 active-low request lines and reports, as an active-high 5-bit number, the highest-numbered request that is currently asserted, together with an active-high flag that is set whenever any request is asserted. It is purely combinational. Its outputs follow the request lines with no clock and no storage.

The requests are split into four groups of eight, numbered 3 (requests 24 to 31) down to 0 (requests 0 to 7). Each group is served by an 8-request sub-encoder with an active-low enable. Each sub-encoder produces three active-low code bits, an active-low "group has a request" flag, and an active-low "enabled but idle" output. The idle output of each group drives the enable of the next lower group. The top group is always enabled. A lower group can therefore only report a request when every higher group is idle.

The two upper index bits come from the group flags. The three lower index bits come from a NAND across the four groups' code lines. This works because a disabled or idle group holds its code lines high. The overall request flag is the NAND of the four group flags. When no request is asserted, the index is 0.

Top module: `cascade_prio_enc`

## Requirements
- R1: The index output equals the number of the highest-numbered request line that is low. Every request line above that number is high.
- R2: The request-present output is 1 exactly when at least one of the 32 request lines is low.
- R3: When all 32 request lines are high, the index is 0 and the request-present output is 0.
- R4: Any low request among lines 24 to 31 sets index bits 4 and 3 both to 1, whatever the lower lines hold.
- R5: Index bit 4 is 1 exactly when the winning request lies in 16 to 31.
- R6: Index bit 3 is 1 exactly when the winning request lies in 8 to 15 or in 24 to 31.
- R7: Index bits 2 to 0 equal the winning request number modulo 8. Requests in lower-priority groups never change them.
- R8: With all 32 request lines low, the index is 31 and the request-present output is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_n | input | 32 | Request lines, active low; bit k is request k |
| idx | output | 5 | Active-high number of the highest asserted request, 0 when idle |
| any_req | output | 1 | Active high, set when at least one request is asserted |

## Verification
The bench sweeps every single request and every pair of requests. It also walks a bit with all lower lines asserted, and applies the all-idle and all-asserted patterns plus random fills. Each result is compared against a scan that runs from line 31 down to line 0. A broken enable chain would let a lower group's code bits merge into the low index bits and produce a number that matches neither request, which the pair sweep exposes at group boundaries. A swapped group-bit derivation would misplace whole octets. An idle group that drove its code lines low would leave a nonzero index, or a false request flag, in the all-idle case.

// File: rtl/cascade_prio_enc_pkg.sv
package cascade_prio_enc_pkg;

  localparam int unsigned CPE_GROUP_W = 8;
  localparam int unsigned CPE_GROUPS  = 4;

  // Bit j of a group number: decides whether that group's flag feeds index bit j
  function automatic logic grp_sel(input int unsigned grp, input int unsigned j);
    return ((grp >> j) & 1) == 1;
  endfunction

endpackage

// File: rtl/cpe_group_enc.sv
// One 8-request (parameterised) encoder with active-low enable, active-low I/O.
module cpe_group_enc #(
  parameter int unsigned W  = 8,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic          en_n,
  input  logic [W-1:0]  req_n,
  output logic [CW-1:0] code_n,
  output logic          gs_n,
  output logic          eo_n
);

  logic [CW-1:0] hi_num;
  logic          found;

  always_comb begin
    hi_num = '0;
    found  = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (!req_n[i]) begin
        hi_num = CW'(i);
        found  = 1'b1;
      end
    end
  end

  always_comb begin
    if (en_n) begin
      code_n = '1;
      gs_n   = 1'b1;
      eo_n   = 1'b1;
    end else if (found) begin
      code_n = ~hi_num;
      gs_n   = 1'b0;
      eo_n   = 1'b1;
    end else begin
      code_n = '1;
      gs_n   = 1'b1;
      eo_n   = 1'b0;
    end
  end

endmodule

// File: rtl/cpe_merge.sv
// Combines the group flags and code lines into the final active-high outputs.
module cpe_merge
  import cascade_prio_enc_pkg::*;
#(
  parameter int unsigned GROUPS = 4,
  parameter int unsigned CW     = 3,
  localparam int unsigned GW    = $clog2(GROUPS)
) (
  input  logic [GROUPS-1:0]    gs_n,
  input  logic [GROUPS*CW-1:0] code_n,
  output logic [GW+CW-1:0]     idx,
  output logic                 any_req
);

  // Low bits: NAND of each code line across all groups
  for (genvar b = 0; b < CW; b++) begin : g_low
    logic [GROUPS-1:0] col_n;
    for (genvar g = 0; g < GROUPS; g++) begin : g_col
      assign col_n[g] = code_n[g*CW + b];
    end
    assign idx[b] = ~&col_n;
  end

  // Group bits: OR of the flags of groups whose number has that bit set
  for (genvar j = 0; j < GW; j++) begin : g_grp
    logic [GROUPS-1:0] hit;
    for (genvar g = 0; g < GROUPS; g++) begin : g_hit
      if (grp_sel(g, j)) begin : g_on
        assign hit[g] = ~gs_n[g];
      end else begin : g_off
        assign hit[g] = 1'b0;
      end
    end
    assign idx[CW+j] = |hit;
  end

  assign any_req = ~&gs_n;

endmodule

// File: rtl/cascade_prio_enc.sv
module cascade_prio_enc
  import cascade_prio_enc_pkg::*;
#(
  parameter int unsigned GROUP_W = CPE_GROUP_W,
  parameter int unsigned GROUPS  = CPE_GROUPS,
  localparam int unsigned NREQ   = GROUP_W * GROUPS,
  localparam int unsigned CW     = $clog2(GROUP_W),
  localparam int unsigned IW     = $clog2(NREQ)
) (
  input  logic [NREQ-1:0] req_n,
  output logic [IW-1:0]   idx,
  output logic            any_req
);

  logic [GROUPS-1:0]    en_n;
  logic [GROUPS-1:0]    eo_n;
  logic [GROUPS-1:0]    gs_n;
  logic [GROUPS*CW-1:0] code_n;

  // Top group always enabled; each group's idle output enables the next lower one
  assign en_n[GROUPS-1] = 1'b0;
  for (genvar g = GROUPS - 1; g > 0; g--) begin : g_chain
    assign en_n[g-1] = eo_n[g];
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    cpe_group_enc #(.W(GROUP_W)) u_enc (
      .en_n   (en_n[g]),
      .req_n  (req_n[g*GROUP_W +: GROUP_W]),
      .code_n (code_n[g*CW +: CW]),
      .gs_n   (gs_n[g]),
      .eo_n   (eo_n[g])
    );
  end

  // Lowest group's idle output is the block-wide "nothing" signal; the
  // merge derives the flag from the group flags instead.
  logic unused_last_eo;
  assign unused_last_eo = eo_n[0];

  cpe_merge #(.GROUPS(GROUPS), .CW(CW)) u_merge (
    .gs_n    (gs_n),
    .code_n  (code_n),
    .idx     (idx),
    .any_req (any_req)
  );

endmodule

// File: rtl/cascade_prio_enc_chk.sv
module cascade_prio_enc_chk #(
  parameter int unsigned NREQ = 32,
  localparam int unsigned IW  = $clog2(NREQ)
) (
  input logic [NREQ-1:0] req_n,
  input logic [IW-1:0]   idx,
  input logic            any_req
);

  logic [NREQ-1:0] act;
  assign act = ~req_n;

  always_comb begin
    if (!$isunknown({req_n, idx, any_req})) begin
      assert_flag_R2: assert (any_req == (act != '0))
        else $error("R2 request flag mismatch");
      assert_idle_zero_R3: assert (any_req || idx == '0)
        else $error("R3 idle index not zero");
      assert_winner_R1: assert (!any_req || (act >> idx) == NREQ'(1))
        else $error("R1 index is not the highest request");
      if (NREQ == 32) begin
        assert_top_group_R4: assert (act[31:24] == '0 || idx[4:3] == 2'b11)
          else $error("R4 top group not favoured");
        assert_bit4_R5: assert (idx[4] == (act[31:16] != '0))
          else $error("R5 index bit 4 wrong");
      end
    end
  end

endmodule

bind cascade_prio_enc cascade_prio_enc_chk #(.NREQ(NREQ)) u_chk (
  .req_n   (req_n),
  .idx     (idx),
  .any_req (any_req)
);

// File: tb/cascade_prio_enc_tb.sv
module cascade_prio_enc_tb;

  logic        clk;
  logic [31:0] req_n;
  logic [4:0]  idx;
  logic        any_req;
  int          n_chk;
  int          n_fail;
  bit          done;

  cascade_prio_enc u_dut (.req_n(req_n), .idx(idx), .any_req(any_req));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s req_n=%h actual=%0d expected=%0d", tag, req_n, act, exp);
    end
  endtask

  // Apply a pattern, settle away from the edge, compare with a downward scan
  task automatic apply(input logic [31:0] r);
    int win;
    win = -1;
    @(posedge clk);
    req_n = r;
    #2;
    for (int k = 31; k >= 0; k--) begin
      if (!r[k] && win < 0) win = k;
    end
    if (win < 0) begin
      chk("R3 idx", int'(idx), 0);
      chk("R3 any_req", int'(any_req), 0);
    end else begin
      chk("R1 idx", int'(idx), win);
      chk("R2 any_req", int'(any_req), 1);
      chk("R5 bit4", int'(idx[4]), (win >= 16) ? 1 : 0);
      chk("R6 bit3", int'(idx[3]), ((win / 8) % 2));
      chk("R7 low bits", int'(idx[2:0]), win % 8);
      if (win >= 24) chk("R4 group bits", int'(idx[4:3]), 3);
    end
  endtask

  initial begin
    n_chk  = 0;
    n_fail = 0;
    done   = 1'b0;
    req_n  = '1;
    #2;
    chk("R3 initial idx", int'(idx), 0);
    chk("R3 initial any_req", int'(any_req), 0);
    apply('1);
    apply('0);
    chk("R8 all idx", int'(idx), 31);
    chk("R8 all any_req", int'(any_req), 1);
    for (int a = 0; a < 32; a++) apply(~(32'd1 << a));
    for (int a = 0; a < 32; a++) apply(~((32'd2 << a) - 32'd1));
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        apply(~((32'd1 << a) | (32'd1 << b)));
      end
    end
    for (int n = 0; n < 1500; n++) begin
      logic [31:0] r;
      r = $urandom;
      if (n % 3 == 0) r = r | $urandom;
      if (n % 5 == 0) r = r & ~(32'd1 << (n % 32));
      apply(r);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule